// File: doc/BRIEF.md
# Indexed Extension-Word Address Calculator

This block turns a base value (an address register or the program counter, supplied by the caller) and a 16-bit extension word into a 32-bit effective address for indexed addressing. It reads an index value from a 16-entry register file through a combinational read port, sizes and scales it, and then either finishes at once (short form) or runs a small sequence (long form). In the sequence it takes base and outer displacement words from an instruction-word stream and may perform one 32-bit memory read for indirection.

A caller pulses the start input with the base and extension word. Some cycles later the block pulses its done output for one cycle with the address. Displacement words are consumed only on a valid/ready handshake. The indirect read is a plain request held until it is acknowledged.

Top module: `idx_ea_calc`

## Requirements
- R1: The register-file read index is extension bits 15:12 taken as a 4-bit number: entries 0-7 are data registers (bit 15 clear) and entries 8-15 are address registers (bit 15 set), with bits 14:12 giving the register number.
- R2: With extension bit 11 clear, the index is the low 16 bits of the register value, sign-extended to 32 bits; with bit 11 set, all 32 bits are used.
- R3: The index is shifted left by extension bits 10:9 (scale 1, 2, 4 or 8).
- R4: With extension bit 8 clear (short form), the address is base plus the sign-extended bits 7:0 plus the scaled index; no stream word is taken and no memory read is made.
- R5: With bit 8 set (long form), bit 7 set replaces the base with zero and bit 6 set replaces the index with zero.
- R6: Long-form bits 5:4 select the base displacement: 00 or 01 none, 10 one stream word sign-extended, 11 two stream words forming a longword, first word the upper half. The displacement is added to the base.
- R7: Long-form bits 1:0 select the outer displacement with the same encoding (01 meaning zero); its words follow the base displacement words in the stream.
- R8: When bits 1:0 are 00, no memory read is made and the address is base plus base displacement plus index. Otherwise exactly one read is made; the read request and its address stay steady until acknowledged.
- R9: Bit 2 clear adds the index into the read address; bit 2 set adds it after the read instead.
- R10: For indirect forms the final address is the returned read data, plus the index when bit 2 is set, plus the outer displacement.
- R11: Start is taken only while idle; a start during an operation is ignored. Done is high for exactly one cycle per accepted start.
- R12: A stream word is consumed only in a cycle where both valid and ready are high; stalls on valid just delay the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a calculation (taken when idle) |
| base_i | input | 32 | Base value |
| ext_i | input | 16 | Extension word |
| rf_idx_o | output | 4 | Register-file read index |
| rf_data_i | input | 32 | Register-file read data |
| iw_valid_i | input | 1 | Stream word valid |
| iw_data_i | input | 16 | Stream word |
| iw_ready_o | output | 1 | Stream word wanted |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 32 | Memory read address |
| rd_ack_i | input | 1 | Read acknowledge with data |
| rd_data_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle result strobe |
| addr_o | output | 32 | Effective address |

## Verification
The hardest situation to reach is the full long form with both displacements as longwords, post-indexed indirection, stream stalls and a second start arriving mid-operation, since all four must coincide. The bench queues the four displacement words ahead of time, gates stream valid with a periodic stall, delays the memory acknowledge by several cycles and fires a spurious start while the read is pending, then expects one result from the original operands and the stream pointer advanced by exactly four words.

// File: rtl/idx_ea_calc.sv
module idx_ea_calc #(
  parameter int XLEN = 32,
  parameter int WLEN = 16,
  parameter int RFAW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [WLEN-1:0] ext_i,
  output logic [RFAW-1:0] rf_idx_o,
  input  logic [XLEN-1:0] rf_data_i,
  input  logic            iw_valid_i,
  input  logic [WLEN-1:0] iw_data_i,
  output logic            iw_ready_o,
  output logic            rd_req_o,
  output logic [XLEN-1:0] rd_addr_o,
  input  logic            rd_ack_i,
  input  logic [XLEN-1:0] rd_data_i,
  output logic            done_o,
  output logic [XLEN-1:0] addr_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_IDX, S_BDH, S_BDL, S_ODH, S_ODL, S_MEM, S_SUM
  } st_t;

  st_t            st;
  logic [WLEN-1:0] ext_r;
  logic [XLEN-1:0] base_r, idx_r, od_r;
  logic [WLEN-1:0] hi_r;

  logic [XLEN-1:0] idx_ext, idx_scl, idx_eff, base_eff, sext8, w_sext, w_long;
  logic            take;
  st_t             after_bd;

  assign rf_idx_o  = ext_r[15:12];
  assign idx_ext   = ext_r[11] ? rf_data_i : {{(XLEN-WLEN){rf_data_i[WLEN-1]}}, rf_data_i[WLEN-1:0]};
  assign idx_scl   = idx_ext << ext_r[10:9];
  assign idx_eff   = (ext_r[8] && ext_r[6]) ? '0 : idx_scl;
  assign base_eff  = (ext_r[8] && ext_r[7]) ? '0 : base_r;
  assign sext8     = {{(XLEN-8){ext_r[7]}}, ext_r[7:0]};
  assign w_sext    = {{(XLEN-WLEN){iw_data_i[WLEN-1]}}, iw_data_i};
  assign w_long    = {hi_r, iw_data_i};
  assign iw_ready_o = (st == S_BDH) || (st == S_BDL) || (st == S_ODH) || (st == S_ODL);
  assign take      = iw_valid_i && iw_ready_o;
  assign rd_req_o  = (st == S_MEM);
  assign rd_addr_o = base_r + (ext_r[2] ? '0 : idx_r);
  assign after_bd  = ext_r[1] ? S_ODH : (ext_r[0] ? S_MEM : S_SUM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ext_r  <= '0;
      base_r <= '0;
      idx_r  <= '0;
      od_r   <= '0;
      hi_r   <= '0;
      done_o <= 1'b0;
      addr_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          ext_r  <= ext_i;
          base_r <= base_i;
          od_r   <= '0;
          st     <= S_IDX;
        end
        S_IDX: begin
          idx_r <= idx_eff;
          if (!ext_r[8]) begin
            addr_o <= base_r + sext8 + idx_scl;
            done_o <= 1'b1;
            st     <= S_IDLE;
          end else begin
            base_r <= base_eff;
            st     <= ext_r[5] ? S_BDH : after_bd;
          end
        end
        S_BDH: if (take) begin
          if (ext_r[4]) begin
            hi_r <= iw_data_i;
            st   <= S_BDL;
          end else begin
            base_r <= base_r + w_sext;
            st     <= after_bd;
          end
        end
        S_BDL: if (take) begin
          base_r <= base_r + w_long;
          st     <= after_bd;
        end
        S_ODH: if (take) begin
          if (ext_r[0]) begin
            hi_r <= iw_data_i;
            st   <= S_ODL;
          end else begin
            od_r <= w_sext;
            st   <= S_MEM;
          end
        end
        S_ODL: if (take) begin
          od_r <= w_long;
          st   <= S_MEM;
        end
        S_MEM: if (rd_ack_i) begin
          addr_o <= rd_data_i + (ext_r[2] ? idx_r : '0) + od_r;
          done_o <= 1'b1;
          st     <= S_IDLE;
        end
        S_SUM: begin
          addr_o <= base_r + idx_r;
          done_o <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start_i) |=> $stable(ext_r));

  p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  p_no_read_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (ext_r[1:0] != 2'b00));

  p_short_no_stream_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iw_ready_o || rd_req_o) |-> ext_r[8]);

  p_scaled_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDX && ext_r[10:9] != 2'b00) |=> !idx_r[0]);

endmodule

// File: tb/idx_ea_calc_test.sv
module idx_ea_calc_test;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] base = 0, rf_data, rd_addr, rd_data = 0, addr;
  logic [15:0] ext = 0, iw_data;
  logic [3:0]  rf_idx;
  logic        iw_valid, iw_ready, rd_req, rd_ack = 0, done;

  always #5 clk = ~clk;

  idx_ea_calc uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .ext_i(ext),
    .rf_idx_o(rf_idx), .rf_data_i(rf_data), .iw_valid_i(iw_valid), .iw_data_i(iw_data),
    .iw_ready_o(iw_ready), .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack),
    .rd_data_i(rd_data), .done_o(done), .addr_o(addr));

  int checks = 0, errors = 0, done_cnt = 0, rd_cnt = 0, cyc = 0, sp = 0, sq_n = 0, dly = 0;
  logic [31:0] rf [16];
  logic [15:0] sq [0:255];
  logic [31:0] exp_q [$];
  logic        done_d = 0;

  assign rf_data  = rf[rf_idx];
  assign iw_valid = (sp < sq_n) && (cyc % 3 != 1);
  assign iw_data  = sq[sp[7:0]];

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (iw_valid && iw_ready) sp <= sp + 1;
    rd_ack <= 1'b0;
    if (rd_req && !rd_ack) begin
      if (dly == 4) begin
        rd_ack  <= 1'b1;
        rd_data <= memf(rd_addr);
        rd_cnt  <= rd_cnt + 1;
        dly     <= 0;
      end else dly <= dly + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done && done_d) chk("R11 done pulse", 32'd1, 32'd0);
      if (done) begin
        if (exp_q.size() == 0) chk("R11 unexpected done", 32'd1, 32'd0);
        else chk("R1-style address (R4/R10)", addr, exp_q.pop_front());
        done_cnt++;
      end
    end
    done_d = done;
  end

  function automatic logic [31:0] model(input logic [31:0] b, input logic [15:0] e,
      input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
      input logic [15:0] w3, output int nrd);
    logic [15:0] w [4];
    logic [31:0] x, od, ia;
    int wp;
    w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
    x = e[11] ? rf[e[15:12]] : {{16{rf[e[15:12]][15]}}, rf[e[15:12]][15:0]};
    x = x << e[10:9];
    nrd = 0;
    if (!e[8]) return b + {{24{e[7]}}, e[7:0]} + x;
    if (e[7]) b = 0;
    if (e[6]) x = 0;
    wp = 0;
    if (e[5:4] == 2'b10) begin b = b + {{16{w[wp][15]}}, w[wp]}; wp++; end
    if (e[5:4] == 2'b11) begin b = b + {w[wp], w[wp+1]}; wp += 2; end
    od = 0;
    if (e[1:0] == 2'b10) od = {{16{w[wp][15]}}, w[wp]};
    if (e[1:0] == 2'b11) od = {w[wp], w[wp+1]};
    if (e[1:0] == 2'b00) return b + x;
    nrd = 1;
    ia = b + (e[2] ? 32'd0 : x);
    return memf(ia) + (e[2] ? x : 32'd0) + od;
  endfunction

  task automatic run(input string tag, input logic [31:0] b, input logic [15:0] e, input int nw,
      input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2, input logic [15:0] w3);
    int nrd, d0, r0, s0;
    logic [15:0] wl [4];
    wl[0] = w0; wl[1] = w1; wl[2] = w2; wl[3] = w3;
    for (int i = 0; i < nw; i++) begin sq[sq_n[7:0]] = wl[i]; sq_n++; end
    exp_q.push_back(model(b, e, w0, w1, w2, w3, nrd));
    d0 = done_cnt; r0 = rd_cnt; s0 = sp;
    @(negedge clk); base = b; ext = e; start = 1;
    @(negedge clk); start = 0; base = 32'hDEAD_BEEF; ext = 16'hFFFF;
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk({tag, " R8 read count"}, rd_cnt - r0, nrd);
    chk({tag, " R12 words taken"}, sp - s0, nw);
    chk({tag, " R11 one done"}, done_cnt - d0, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h0001_8000 + i * 32'h0011_0101;
    repeat (2) @(negedge clk);
    chk("R11 reset done", {31'd0, done}, 0);
    chk("R12 reset ready", {31'd0, iw_ready}, 0);
    chk("R8 reset req", {31'd0, rd_req}, 0);
    rst_n = 1;
    run("R1 R2 R4 short D3 word", 32'h0000_4000, 16'h30FC, 0, 0, 0, 0, 0);
    run("R1 R2 R3 short A5 long x4", 32'h1000_0000, 16'hDC10, 0, 0, 0, 0, 0);
    run("R3 R4 short x8", 32'h0200_0000, 16'h067F, 0, 0, 0, 0, 0);
    run("R5 R8 long direct", 32'h0000_1000, 16'h9B10, 0, 0, 0, 0, 0);
    run("R5 R6 base suppressed word bd", 32'h7777_0000, 16'h21A0, 1, 16'hFFF0, 0, 0, 0);
    run("R5 R6 index suppressed long bd", 32'h0000_0010, 16'h7F70, 2, 16'h1234, 16'h5678, 0, 0);
    run("R7 R9 pre-indexed", 32'h0004_0000, 16'hFB22, 2, 16'h0100, 16'hFFFE, 0, 0);
    run("R7 R9 R10 post long/long", 32'h0000_2000, 16'h4537, 4, 16'h0002, 16'h0000, 16'h8000, 16'h0001);
    run("R7 R10 null outer", 32'h5555_5555, 16'h6991, 0, 0, 0, 0, 0);
    run("R5 R10 both suppressed", 32'h9999_0000, 16'h01F6, 3, 16'h0000, 16'h4000, 16'h0010, 0);
    fork
      run("R11 start ignored while busy", 32'h0000_3000, 16'h4537, 4, 16'h0001, 16'h0002, 16'hFFFF, 16'hFFF0);
      begin
        repeat (9) @(negedge clk);
        base = 32'h0BAD_0000; ext = 16'h30FC; start = 1;
        @(negedge clk); start = 0;
      end
    join
    chk("R11 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule